// File: doc/BRIEF.md
# Derivative-on-Measurement PID Duty Compensator

This block is a fixed-point discrete-time compensator for a step-down switching converter. It runs one control update for each sample strobe. Each update takes a signed reference word and a signed measured-output word, and it returns a saturated duty word together with a one-cycle valid pulse. Proportional and integral action work on the error, which is the reference minus the measurement with unit sensor gain. The integral is a forward-Euler accumulator. The first-order-filtered derivative works only on the measurement and is subtracted from the sum, so a step in the reference injects no derivative impulse into the duty command.

A second control law can be selected at run time. It evaluates a five-coefficient difference equation on the error and on the past duty outputs, so the two laws can be compared directly. All gains, the filter constants, the duty limits and the law select are precomputed fixed-point words. They are written through a small address/data port into shadow registers. The shadow contents are copied to the working set only when a sample strobe arrives, so a single update never mixes old and new settings.

Top module: `pidm_core`

## Requirements
- R1: `duty_o` and a single-cycle `valid_o` pulse appear exactly 2 clock edges after the edge that samples `sample_i`. `duty_o` does not change while `valid_o` is low.
- R2: The error is e = ref - meas. Every product is rounded as round(c*v) = (c*v + 2^14) >> 15 (arithmetic shift), with coefficients in Q15 (32768 = 1.0). In PID law the proportional term is round(kp*e).
- R3: The integral state I starts at 0. Each update outputs P + I - D using the current I, and afterwards I becomes I + round(ki*e). The error of sample n therefore reaches the output first at sample n+1.
- R4: The derivative state D is updated as D = round(kda*D_prev) + round(kdb*(meas - meas_prev)) and is subtracted from the sum. A change of the reference alone never enters D.
- R5: The first update after reset uses meas_prev = meas, so it carries no derivative contribution.
- R6: The duty is a 15-bit unsigned fraction of one (always below 100%). It is clamped to [lo, hi]: hi when the sum is above hi, otherwise lo when the sum is below lo.
- R7: When the sum clamps at hi with e > 0, or at lo with e < 0, I keeps its value for that update.
- R8: In difference-equation law, d = round(a*d1) + round(b*d2) + round(g*e) + round(l*e1) + round(m*e2), clamped as in R6. Here d1 and d2 are the previous two duty outputs and e1 and e2 are the previous two errors. These histories advance on every update in either law. I and D hold while this law is active.
- R9: Settings written through the configuration port take effect at the next sample strobe. A write issued while an update is in flight does not affect that update. Addresses: 0 kp, 1 ki, 2 kda, 3 kdb, 4 a, 5 b, 6 g, 7 l, 8 m, 9 lo, 10 hi, 11 law select.
- R10: After reset, `duty_o` = 0 and `valid_o` = 0. All coefficients, states and histories are 0, lo = 0, hi = 32767, and the PID law is selected.
- R11: Bit 0 of address 11 selects the law: 0 = PID with derivative on measurement, 1 = difference equation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Sample strobe qualifying ref_i and meas_i |
| ref_i | input | 16 | Signed reference word |
| meas_i | input | 16 | Signed measured-output word |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 18 | Configuration write data (signed Q15 coefficient or limit) |
| duty_o | output | 15 | Duty command, unsigned fraction of one |
| valid_o | output | 1 | One-cycle pulse marking a new duty_o |

## Verification
The hardest case to reach from the ports is integrator hold under saturation. Its effect shows up only one update after the clamp has ended. The stimulus holds a large error against a low upper limit for several samples, then drops the error inside the limits, where a wound-up integral would give a visibly larger duty. The second hard case is a configuration write landing while an update is in flight. The bench issues that write in the cycle right after the strobe and expects the old gain on that update and the new gain on the following one. The first-sample derivative rule is reached by resetting with a derivative gain loaded and a large measurement present.

// File: rtl/pidm_pkg.sv
package pidm_pkg;
   typedef enum logic {
      LAW_PID    = 1'b0,
      LAW_DIRECT = 1'b1
   } law_e;

   localparam int unsigned N_REG  = 12;
   localparam int unsigned N_LANE = 5;

   localparam int unsigned A_KP     = 0;
   localparam int unsigned A_KI     = 1;
   localparam int unsigned A_KDA    = 2;
   localparam int unsigned A_KDB    = 3;
   localparam int unsigned A_ALPHA  = 4;
   localparam int unsigned A_BETA   = 5;
   localparam int unsigned A_GAMMA  = 6;
   localparam int unsigned A_LAMBDA = 7;
   localparam int unsigned A_MU     = 8;
   localparam int unsigned A_LO     = 9;
   localparam int unsigned A_HI     = 10;
   localparam int unsigned A_MODE   = 11;
endpackage

// File: rtl/pidm_coef_bank.sv
module pidm_coef_bank
   import pidm_pkg::*;
#(
   parameter int COEF_W = 18,
   parameter int ADDR_W = 4,
   parameter int DUTY_W = 15
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic signed [COEF_W-1:0] wr_data,
   input  logic                     commit,
   output logic signed [COEF_W-1:0] act_o [N_REG]
);
   logic signed [COEF_W-1:0] shadow [N_REG];

   initial begin
      assert (COEF_W > DUTY_W) else $error("COEF_W must exceed DUTY_W");
      assert ((1 << ADDR_W) >= N_REG) else $error("ADDR_W too small for register count");
   end

   for (genvar i = 0; i < N_REG; i++) begin : g_reg
      localparam logic signed [COEF_W-1:0] RST_VAL =
         (i == A_HI) ? COEF_W'((1 << DUTY_W) - 1) : '0;

      always_ff @(posedge clk) begin
         if (rst) begin
            shadow[i] <= RST_VAL;
            act_o[i]  <= RST_VAL;
         end else begin
            if (wr_en && (wr_addr == ADDR_W'(i)))
               shadow[i] <= wr_data;
            if (commit)
               act_o[i] <= shadow[i];
         end
      end
   end
endmodule

// File: rtl/pidm_lane_mul.sv
module pidm_lane_mul #(
   parameter int COEF_W = 18,
   parameter int OPND_W = 32,
   parameter int FRAC   = 15,
   parameter int OUT_W  = 32
) (
   input  logic signed [COEF_W-1:0] c,
   input  logic signed [OPND_W-1:0] v,
   output logic signed [OUT_W-1:0]  p
);
   localparam int PW = COEF_W + OPND_W;
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

   logic signed [PW-1:0] full;
   logic signed [PW-1:0] biased;

   initial begin
      assert (FRAC > 0 && FRAC < COEF_W) else $error("FRAC out of range");
      assert (PW - FRAC >= OUT_W) else $error("product narrower than lane output");
   end

   always_comb begin
      full   = PW'(c) * PW'(v);
      biased = full + HALF;
      p      = OUT_W'(biased >>> FRAC);
   end
endmodule

// File: rtl/pidm_limit.sv
module pidm_limit #(
   parameter int ACC_W  = 32,
   parameter int DUTY_W = 15
) (
   input  logic signed [ACC_W-1:0] u,
   input  logic [DUTY_W-1:0]       lo,
   input  logic [DUTY_W-1:0]       hi,
   output logic [DUTY_W-1:0]       y,
   output logic                    hi_hit,
   output logic                    lo_hit
);
   logic signed [ACC_W-1:0] lo_ext;
   logic signed [ACC_W-1:0] hi_ext;

   initial begin
      assert (ACC_W > DUTY_W + 1) else $error("ACC_W too narrow for duty range");
   end

   always_comb begin
      lo_ext = ACC_W'(lo);
      hi_ext = ACC_W'(hi);
      hi_hit = (u > hi_ext);
      lo_hit = !hi_hit && (u < lo_ext);
      if (hi_hit)
         y = hi;
      else if (lo_hit)
         y = lo;
      else
         y = DUTY_W'(u);
   end
endmodule

// File: rtl/pidm_core.sv
module pidm_core
   import pidm_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 18,
   parameter int FRAC   = 15,
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sample_i,
   input  logic signed [DATA_W-1:0] ref_i,
   input  logic signed [DATA_W-1:0] meas_i,
   input  logic                     cfg_we,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic signed [COEF_W-1:0] cfg_wdata,
   output logic [DATA_W-2:0]        duty_o,
   output logic                     valid_o
);
   localparam int DUTY_W = DATA_W - 1;
   localparam int ERR_W  = DATA_W + 1;

   initial begin
      assert (ACC_W >= ERR_W + 2) else $error("ACC_W must exceed error width");
      assert (DATA_W >= 4) else $error("DATA_W too small");
   end

   logic signed [COEF_W-1:0] coef [N_REG];
   law_e                     law;
   logic [DUTY_W-1:0]        lim_lo;
   logic [DUTY_W-1:0]        lim_hi;

   pidm_coef_bank #(
      .COEF_W (COEF_W),
      .ADDR_W (ADDR_W),
      .DUTY_W (DUTY_W)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .commit  (sample_i),
      .act_o   (coef)
   );

   assign law    = law_e'(coef[A_MODE][0]);
   assign lim_lo = coef[A_LO][DUTY_W-1:0];
   assign lim_hi = coef[A_HI][DUTY_W-1:0];

   logic signed [DATA_W-1:0] ref_q;
   logic signed [DATA_W-1:0] meas_q;
   logic signed [DATA_W-1:0] meas_prev;
   logic                     go;
   logic                     primed;
   logic signed [ERR_W-1:0]  e1;
   logic signed [ERR_W-1:0]  e2;
   logic [DUTY_W-1:0]        d1;
   logic [DUTY_W-1:0]        d2;
   logic signed [ACC_W-1:0]  integ;
   logic signed [ACC_W-1:0]  dstate;

   logic signed [ERR_W-1:0]  err;
   logic signed [ERR_W-1:0]  dy;
   logic signed [DATA_W-1:0] x_prev;

   always_comb begin
      x_prev = primed ? meas_prev : meas_q;
      err    = ERR_W'(ref_q) - ERR_W'(meas_q);
      dy     = ERR_W'(meas_q) - ERR_W'(x_prev);
   end

   logic signed [COEF_W-1:0] lane_c [N_LANE];
   logic signed [ACC_W-1:0]  lane_v [N_LANE];
   logic signed [ACC_W-1:0]  lane_p [N_LANE];

   always_comb begin
      for (int k = 0; k < N_LANE; k++) begin
         lane_c[k] = '0;
         lane_v[k] = '0;
      end
      if (law == LAW_PID) begin
         lane_c[0] = coef[A_KP];     lane_v[0] = ACC_W'(err);
         lane_c[1] = coef[A_KI];     lane_v[1] = ACC_W'(err);
         lane_c[2] = coef[A_KDA];    lane_v[2] = dstate;
         lane_c[3] = coef[A_KDB];    lane_v[3] = ACC_W'(dy);
      end else begin
         lane_c[0] = coef[A_ALPHA];  lane_v[0] = ACC_W'({1'b0, d1});
         lane_c[1] = coef[A_BETA];   lane_v[1] = ACC_W'({1'b0, d2});
         lane_c[2] = coef[A_GAMMA];  lane_v[2] = ACC_W'(err);
         lane_c[3] = coef[A_LAMBDA]; lane_v[3] = ACC_W'(e1);
         lane_c[4] = coef[A_MU];     lane_v[4] = ACC_W'(e2);
      end
   end

   for (genvar k = 0; k < N_LANE; k++) begin : g_lane
      pidm_lane_mul #(
         .COEF_W (COEF_W),
         .OPND_W (ACC_W),
         .FRAC   (FRAC),
         .OUT_W  (ACC_W)
      ) u_mul (
         .c (lane_c[k]),
         .v (lane_v[k]),
         .p (lane_p[k])
      );
   end

   logic signed [ACC_W-1:0] d_new;
   logic signed [ACC_W-1:0] u_sum;
   logic [DUTY_W-1:0]       y_lim;
   logic                    hi_hit;
   logic                    lo_hit;
   logic                    hold;

   always_comb begin
      d_new = lane_p[2] + lane_p[3];
      if (law == LAW_PID)
         u_sum = lane_p[0] + integ - d_new;
      else
         u_sum = lane_p[0] + lane_p[1] + lane_p[2] + lane_p[3] + lane_p[4];
   end

   pidm_limit #(
      .ACC_W  (ACC_W),
      .DUTY_W (DUTY_W)
   ) u_lim (
      .u      (u_sum),
      .lo     (lim_lo),
      .hi     (lim_hi),
      .y      (y_lim),
      .hi_hit (hi_hit),
      .lo_hit (lo_hit)
   );

   always_comb begin
      hold = (hi_hit && !err[ERR_W-1] && (err != '0)) ||
             (lo_hit && err[ERR_W-1]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q     <= '0;
         meas_q    <= '0;
         meas_prev <= '0;
         go        <= 1'b0;
         primed    <= 1'b0;
         e1        <= '0;
         e2        <= '0;
         d1        <= '0;
         d2        <= '0;
         integ     <= '0;
         dstate    <= '0;
         duty_o    <= '0;
         valid_o   <= 1'b0;
      end else begin
         go      <= sample_i;
         valid_o <= go;
         if (sample_i) begin
            ref_q  <= ref_i;
            meas_q <= meas_i;
         end
         if (go) begin
            duty_o    <= y_lim;
            primed    <= 1'b1;
            meas_prev <= meas_q;
            e1        <= err;
            e2        <= e1;
            d1        <= y_lim;
            d2        <= d1;
            if (law == LAW_PID) begin
               dstate <= d_new;
               if (!hold)
                  integ <= integ + lane_p[1];
            end
         end
      end
   end
endmodule

// File: rtl/pidm_core_chk.sv
module pidm_core_chk #(
   parameter int DUTY_W = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              sample_i,
   input logic              valid_o,
   input logic [DUTY_W-1:0] duty_o,
   input logic [DUTY_W-1:0] lim_lo,
   input logic [DUTY_W-1:0] lim_hi
);
   // R1: every strobe yields a valid pulse two edges later
   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
      sample_i |-> ##2 valid_o);

   // R1: no valid pulse without a strobe two edges earlier
   assert_valid_source_R1: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(sample_i, 2));

   // R1: duty only moves together with a valid pulse
   assert_duty_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> $stable(duty_o));

   // R6: the published duty lies within the limits used for that update
   assert_duty_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (duty_o <= $past(lim_hi)) && (duty_o >= $past(lim_lo)));

   // R10: state right after reset
   assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (duty_o == '0) && !valid_o);
endmodule

bind pidm_core pidm_core_chk #(.DUTY_W(DUTY_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sample_i (sample_i),
   .valid_o  (valid_o),
   .duty_o   (duty_o),
   .lim_lo   (lim_lo),
   .lim_hi   (lim_hi)
);

// File: tb/sim_pidm_core.sv
`timescale 1ns/1ps
module sim_pidm_core;
   localparam int DATA_W = 16;
   localparam int COEF_W = 18;
   localparam int ADDR_W = 4;
   localparam int FRAC   = 15;

   logic                     clk = 1'b0;
   logic                     rst = 1'b1;
   logic                     sample_i = 1'b0;
   logic signed [DATA_W-1:0] ref_i = '0;
   logic signed [DATA_W-1:0] meas_i = '0;
   logic                     cfg_we = 1'b0;
   logic [ADDR_W-1:0]        cfg_addr = '0;
   logic signed [COEF_W-1:0] cfg_wdata = '0;
   logic [DATA_W-2:0]        duty_o;
   logic                     valid_o;

   always #10 clk = ~clk;

   pidm_core u0 (
      .clk       (clk),
      .rst       (rst),
      .sample_i  (sample_i),
      .ref_i     (ref_i),
      .meas_i    (meas_i),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .duty_o    (duty_o),
      .valid_o   (valid_o)
   );

   typedef struct {
      longint exp;
      string  tag;
   } item_t;

   item_t  sb[$];
   int     n_chk = 0;
   int     n_fail = 0;

   // reference model state
   longint shadow [12];
   longint act [12];
   longint m_integ, m_dst, m_mprev, m_e1, m_e2, m_d1, m_d2;
   bit     m_primed;

   function automatic longint rnd(longint c, longint v);
      return (c * v + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 12; i++) begin
         shadow[i] = 0;
         act[i]    = 0;
      end
      shadow[10] = 32767;
      act[10]    = 32767;
      m_integ = 0; m_dst = 0; m_mprev = 0;
      m_e1 = 0; m_e2 = 0; m_d1 = 0; m_d2 = 0;
      m_primed = 0;
   endtask

   // commit shadow, compute the expected duty, push it on the scoreboard
   task automatic model_step(longint r, longint m, string tag);
      longint e, xp, dy, u, dn, lo, hi, y;
      bit     hh, lh;
      item_t  it;
      for (int i = 0; i < 12; i++) act[i] = shadow[i];
      e  = r - m;
      xp = m_primed ? m_mprev : m;
      dy = m - xp;
      lo = act[9] & 32767;
      hi = act[10] & 32767;
      dn = 0;
      if ((act[11] & 1) == 0) begin
         dn = rnd(act[2], m_dst) + rnd(act[3], dy);
         u  = rnd(act[0], e) + m_integ - dn;
      end else begin
         u = rnd(act[4], m_d1) + rnd(act[5], m_d2) + rnd(act[6], e) +
             rnd(act[7], m_e1) + rnd(act[8], m_e2);
      end
      hh = (u > hi);
      lh = !hh && (u < lo);
      y  = hh ? hi : (lh ? lo : u);
      if ((act[11] & 1) == 0) begin
         m_dst = dn;
         if (!((hh && e > 0) || (lh && e < 0)))
            m_integ = m_integ + rnd(act[1], e);
      end
      m_primed = 1;
      m_mprev  = m;
      m_e2 = m_e1; m_e1 = e;
      m_d2 = m_d1; m_d1 = y;
      it.exp = y;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic cfg_write(int addr, longint data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = ADDR_W'(addr);
      cfg_wdata = COEF_W'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      shadow[addr] = data;
   endtask

   task automatic apply(longint r, longint m, string tag);
      @(negedge clk);
      ref_i    = DATA_W'(r);
      meas_i   = DATA_W'(m);
      sample_i = 1'b1;
      model_step(r, m, tag);
      @(negedge clk);
      sample_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // strobe, then a configuration write in the cycle the update is in flight
   task automatic apply_with_write(longint r, longint m, int addr, longint data, string tag);
      @(negedge clk);
      ref_i    = DATA_W'(r);
      meas_i   = DATA_W'(m);
      sample_i = 1'b1;
      model_step(r, m, tag);
      @(negedge clk);
      sample_i  = 1'b0;
      cfg_we    = 1'b1;
      cfg_addr  = ADDR_W'(addr);
      cfg_wdata = COEF_W'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      shadow[addr] = data;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   // monitor: pop and compare on every valid pulse
   always @(negedge clk) begin
      if (!rst && valid_o) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R1: unexpected valid pulse, duty actual %0d expected none", duty_o);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (longint'(duty_o) != it.exp) begin
               n_fail++;
               $display("FAIL %s: duty actual %0d expected %0d", it.tag, duty_o, it.exp);
            end
         end
      end
   end

   task automatic finish_run();
      n_fail += sb.size();
      n_chk  += sb.size();
      if (sb.size() != 0)
         $display("FAIL R1: %0d updates never produced a valid pulse (actual) vs 0 expected", sb.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R10 reset state at the ports
      n_chk++;
      if (duty_o !== '0 || valid_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R10: duty/valid actual %0d/%0b expected 0/0", duty_o, valid_o);
      end

      // R2 proportional path, R6 lower clamp at 0
      cfg_write(0, 16384);
      apply(8192, 0, "R2");
      apply(20000, 4000, "R2");
      apply(-8192, 0, "R6");

      // R3 integral one sample late
      cfg_write(0, 0);
      cfg_write(1, 3277);
      apply(10000, 0, "R3");
      apply(10000, 0, "R3");
      apply(0, 0, "R3");

      // R4 derivative on measurement only
      cfg_write(1, 0);
      cfg_write(2, 16384);
      cfg_write(3, 32768);
      apply(5000, 0, "R4");
      apply(15000, 0, "R4");
      apply(15000, 0, "R4");
      apply(15000, 1000, "R4");
      apply(15000, 1000, "R4");

      // R6 programmable clamp, both ends, and full scale below one
      cfg_write(2, 0);
      cfg_write(3, 0);
      cfg_write(0, 65536);
      cfg_write(9, 1000);
      cfg_write(10, 20000);
      apply(30000, 0, "R6");
      apply(-30000, 0, "R6");
      cfg_write(9, 0);
      cfg_write(10, 32767);
      apply(32767, -32768, "R6");

      // R5 first sample after reset carries no derivative
      do_reset();
      cfg_write(0, 32768);
      cfg_write(3, 32768);
      apply(20000, 10000, "R5");
      apply(20000, 12000, "R5");

      // R7 anti-windup
      do_reset();
      cfg_write(0, 32768);
      cfg_write(1, 8192);
      cfg_write(10, 20000);
      apply(30000, 0, "R7");
      apply(30000, 0, "R7");
      apply(30000, 0, "R7");
      apply(10000, 5000, "R7");
      apply(10000, 5000, "R7");

      // R9 write during an in-flight update applies only from the next strobe
      apply_with_write(10000, 5000, 0, 0, "R9");
      apply(10000, 5000, "R9");

      // R8 / R11 difference-equation law, then back to PID
      do_reset();
      cfg_write(4, 16384);
      cfg_write(5, -8192);
      cfg_write(6, 32768);
      cfg_write(7, -16384);
      cfg_write(8, 8192);
      cfg_write(0, 32768);
      cfg_write(11, 1);
      apply(6000, 1000, "R8");
      apply(6000, 2000, "R8");
      apply(6000, 3000, "R8");
      apply(4000, 3500, "R8");
      cfg_write(11, 0);
      apply(9000, 3000, "R11");

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule